// File: doc/BRIEF.md
# Rule-Row Fitness Accumulator

This block scores one candidate rule row while a set of labelled training vectors is streamed past it. For every vector the host presents the row's single-bit match result, the category the vector really belongs to, the category the row is being trained to detect, and a reward weight. A vector that belongs to the target class and is accepted earns the weight. A vector from another class that is rejected earns one point. A wrong accept or a wrong reject earns nothing. Only the training part of the image set is streamed. The vectors held back for verification never reach the block.

The running score and the number of vectors seen are plain register outputs. A host can read them in any cycle, with no handshake. A synchronous clear zeroes both before the next candidate is scored. The weight is sampled together with each vector, and a host would normally drive 64. Both totals saturate at their all-ones value and never wrap. By default the score is wide enough for 400 vectors at the largest weight, which covers 40 classes with up to ten images each.

Top module: `row_fitness_acc`

## Requirements
- R1: While `rst_n` is low at a rising edge, `fit_sum` and `sample_cnt` become 0.
- R2: A strobe with `vec_cat` equal to `train_cat` and `row_match` = 1 adds the `tp_weight` value sampled with that strobe to `fit_sum`. This includes a weight of 0.
- R3: A strobe with `vec_cat` different from `train_cat` and `row_match` = 0 adds exactly 1 to `fit_sum`.
- R4: A strobe with a category mismatch and `row_match` = 1, or with a category match and `row_match` = 0, leaves `fit_sum` unchanged.
- R5: Every strobe that is not cancelled by a clear adds 1 to `sample_cnt`, whatever its outcome.
- R6: A strobe sampled at rising edge k changes the outputs just after edge k+1. When `sample_stb` is 0, the other inputs have no effect on either output.
- R7: When `clr` is 1 at a rising edge, both outputs become 0. Any strobe sampled at the same edge, or at the edge before it, is discarded.
- R8: `fit_sum` saturates at all ones. An addition that would exceed that value leaves it at all ones.
- R9: `sample_cnt` saturates at all ones and holds there on further strobes.
- R10: Strobes on consecutive cycles are each accumulated, with no lost samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of score and count |
| sample_stb | input | 1 | One training vector is presented this cycle |
| row_match | input | 1 | Match output of the rule row for this vector |
| vec_cat | input | CAT_W | True category of the vector |
| train_cat | input | CAT_W | Category the row is trained for |
| tp_weight | input | WEIGHT_W | Reward for a correct accept |
| fit_sum | output | SUM_W | Saturating fitness total |
| sample_cnt | output | CNT_W | Saturating count of accepted strobes |

## Verification
The bench builds the block with MAX_SAMPLES = 4, WEIGHT_W = 8 and CAT_W = 6. With those values the score is 10 bits wide and the count is 3 bits wide. Five correct accepts at weight 255 therefore drive the score past 1023, and eight strobes push the count past 7. Both saturation limits are reached within a few dozen cycles. The same short runs also cover every outcome class, a zero weight, back-to-back strobes, idle cycles carrying misleading inputs, and a clear that lands on a strobe still in flight.

// File: rtl/fit_pkg.sv
// Shared types for the row fitness accumulator.
// Assumes: nothing beyond IEEE 1800-2017.
package fit_pkg;

    // Classification of one training vector against the row's decision
    typedef enum logic [1:0] {
        OUT_TRUE_ACC  = 2'd0,
        OUT_TRUE_REJ  = 2'd1,
        OUT_FALSE_ACC = 2'd2,
        OUT_FALSE_REJ = 2'd3
    } outcome_e;

    // Classify one vector from the category match and the row decision
    function automatic outcome_e classify(input logic same_cat, input logic hit);
        if (same_cat) return hit ? OUT_TRUE_ACC : OUT_FALSE_REJ;
        return hit ? OUT_FALSE_ACC : OUT_TRUE_REJ;
    endfunction

endpackage

// File: rtl/fit_sample_stage.sv
// Registers one strobed training vector and turns it into a score increment.
// Correct accept gives the sampled weight, correct reject gives one, errors give zero.
// Assumes: clr has priority and discards the vector sampled at the same edge.
module fit_sample_stage #(
    parameter int CAT_W    = 6,
    parameter int WEIGHT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                sample_stb,
    input  logic                row_match,
    input  logic [CAT_W-1:0]    vec_cat,
    input  logic [CAT_W-1:0]    train_cat,
    input  logic [WEIGHT_W-1:0] tp_weight,
    output logic                stg_vld,
    output logic [WEIGHT_W-1:0] stg_inc
);
    import fit_pkg::*;

    outcome_e            outcome;
    logic [WEIGHT_W-1:0] inc_d;

    // Decide the reward for the vector on the inputs
    always_comb begin
        outcome = classify(vec_cat == train_cat, row_match);
        case (outcome)
            OUT_TRUE_ACC: inc_d = tp_weight;
            OUT_TRUE_REJ: inc_d = WEIGHT_W'(1);
            default:      inc_d = '0;
        endcase
    end

    // Hold the strobe and its reward for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            stg_vld <= 1'b0;
            stg_inc <= '0;
        end else begin
            stg_vld <= sample_stb;
            stg_inc <= sample_stb ? inc_d : '0;
        end
    end

endmodule

// File: rtl/fit_sat_accum.sv
// Saturating accumulator: adds add_val when add_en is high and sticks at all ones.
// Assumes: INC_W <= W.
module fit_sat_accum #(
    parameter int W     = 16,
    parameter int INC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add_en,
    input  logic [INC_W-1:0] add_val,
    output logic [W-1:0]     acc
);
    localparam int PAD_W = W + 1 - INC_W;

    logic [W:0] wide_sum;

    // Form the sum one bit wider so overflow is visible
    always_comb begin
        wide_sum = {1'b0, acc} + {{PAD_W{1'b0}}, add_val};
    end

    // Update the total, clamping at the top of the range
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc <= '0;
        end else if (add_en) begin
            acc <= wide_sum[W] ? {W{1'b1}} : wide_sum[W-1:0];
        end
    end

endmodule

// File: rtl/row_fitness_acc.sv
// Fitness accumulator for one rule row under training.
// Each strobed vector is scored one cycle after sampling; score and count saturate.
// Assumes: host clears between candidates and reads the outputs at will.
module row_fitness_acc #(
    parameter int CAT_W       = 6,
    parameter int WEIGHT_W    = 8,
    parameter int MAX_SAMPLES = 400,
    localparam int SUM_W      = $clog2(MAX_SAMPLES * ((1 << WEIGHT_W) - 1) + 1),
    localparam int CNT_W      = $clog2(MAX_SAMPLES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                sample_stb,
    input  logic                row_match,
    input  logic [CAT_W-1:0]    vec_cat,
    input  logic [CAT_W-1:0]    train_cat,
    input  logic [WEIGHT_W-1:0] tp_weight,
    output logic [SUM_W-1:0]    fit_sum,
    output logic [CNT_W-1:0]    sample_cnt
);
    logic                stg_vld;
    logic [WEIGHT_W-1:0] stg_inc;

    fit_sample_stage #(.CAT_W(CAT_W), .WEIGHT_W(WEIGHT_W)) u_stage (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .sample_stb(sample_stb), .row_match(row_match),
        .vec_cat(vec_cat), .train_cat(train_cat), .tp_weight(tp_weight),
        .stg_vld(stg_vld), .stg_inc(stg_inc)
    );

    fit_sat_accum #(.W(SUM_W), .INC_W(WEIGHT_W)) u_sum (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .add_en(stg_vld), .add_val(stg_inc), .acc(fit_sum)
    );

    fit_sat_accum #(.W(CNT_W), .INC_W(1)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .add_en(stg_vld), .add_val(1'b1), .acc(sample_cnt)
    );

endmodule

// File: rtl/fit_acc_checker.sv
// Temporal checks on the accumulator outputs, bound to row_fitness_acc.
module fit_acc_checker #(
    parameter int SUM_W = 17,
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             sample_stb,
    input logic [SUM_W-1:0] fit_sum,
    input logic [CNT_W-1:0] sample_cnt
);
    logic stb_q;

    // Track a strobe that survived its sampling edge
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= sample_stb && !clr;
    end

    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (fit_sum == '0 && sample_cnt == '0));

    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (fit_sum == '0 && sample_cnt == '0));

    a_r8_sum_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (fit_sum >= $past(fit_sum)));

    a_r8_sum_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && fit_sum == {SUM_W{1'b1}}) |=> (fit_sum == {SUM_W{1'b1}}));

    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (sample_cnt == $past(sample_cnt) || sample_cnt == $past(sample_cnt) + 1'b1));

    a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !stb_q) |=> ($stable(fit_sum) && $stable(sample_cnt)));

endmodule

bind row_fitness_acc fit_acc_checker #(.SUM_W(SUM_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .sample_stb(sample_stb),
    .fit_sum(fit_sum), .sample_cnt(sample_cnt)
);

// File: tb/row_fitness_acc_tb.sv
module row_fitness_acc_tb;
    localparam int CAT_W = 6;
    localparam int WEIGHT_W = 8;
    localparam int MAX_SAMPLES = 4;
    localparam int SUM_W = $clog2(MAX_SAMPLES * ((1 << WEIGHT_W) - 1) + 1);
    localparam int CNT_W = $clog2(MAX_SAMPLES + 1);
    localparam int SUM_MAX = (1 << SUM_W) - 1;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    typedef struct { int sum; int cnt; string tag; } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic sample_stb = 1'b0;
    logic row_match = 1'b0;
    logic [CAT_W-1:0] vec_cat = '0;
    logic [CAT_W-1:0] train_cat = '0;
    logic [WEIGHT_W-1:0] tp_weight = '0;
    logic [SUM_W-1:0] fit_sum;
    logic [CNT_W-1:0] sample_cnt;

    int checks = 0;
    int failures = 0;
    int m_sum = 0;
    int m_cnt = 0;
    exp_t q[$];
    logic p1 = 1'b0;
    logic p2 = 1'b0;
    bit done = 0;

    always #10 clk = ~clk;

    row_fitness_acc #(.CAT_W(CAT_W), .WEIGHT_W(WEIGHT_W), .MAX_SAMPLES(MAX_SAMPLES)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .sample_stb(sample_stb),
        .row_match(row_match), .vec_cat(vec_cat), .train_cat(train_cat),
        .tp_weight(tp_weight), .fit_sum(fit_sum), .sample_cnt(sample_cnt)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: present one vector for one cycle and push the expected totals
    task automatic send(input logic hit, input int cat, input int tgt, input int w, input string tag);
        int inc;
        sample_stb = 1'b1; row_match = hit;
        vec_cat = CAT_W'(cat); train_cat = CAT_W'(tgt); tp_weight = WEIGHT_W'(w);
        if (cat == tgt && hit) inc = w;
        else if (cat != tgt && !hit) inc = 1;
        else inc = 0;
        m_sum = (m_sum + inc > SUM_MAX) ? SUM_MAX : m_sum + inc;
        m_cnt = (m_cnt + 1 > CNT_MAX) ? CNT_MAX : m_cnt + 1;
        q.push_back('{m_sum, m_cnt, tag});
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        sample_stb = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Bench-side pipeline of surviving strobes, used to time the monitor
    always @(posedge clk) begin
        if (!rst_n || clr) begin p1 <= 1'b0; p2 <= 1'b0; end
        else begin p1 <= sample_stb; p2 <= p1; end
    end

    // Monitor: compare the outputs when a scored vector should have landed
    always @(negedge clk) begin
        if (p2) begin
            if (q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R6 actual=unexpected_result expected=none");
            end else begin
                exp_t e;
                e = q.pop_front();
                check({e.tag, " sum"}, int'(fit_sum), e.sum);
                check({e.tag, " cnt"}, int'(sample_cnt), e.cnt);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset sum", int'(fit_sum), 0);
        check("R1 reset cnt", int'(sample_cnt), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Each outcome class, back to back (R10)
        send(1'b1, 39, 39, 64, "R2 true accept w64 R10");
        send(1'b0, 5, 39, 64, "R3 true reject R10");
        send(1'b1, 6, 39, 200, "R4 false accept R10");
        send(1'b0, 39, 39, 200, "R4 false reject R10");
        send(1'b1, 0, 0, 0, "R2 true accept w0 R5");
        idle(4);

        // Misleading inputs with no strobe (R6)
        row_match = 1'b1; vec_cat = 6'd7; train_cat = 6'd7; tp_weight = 8'd255;
        idle(4);
        check("R6 idle sum", int'(fit_sum), 65);
        check("R6 idle cnt", int'(sample_cnt), 5);

        // Clear with one strobe in flight and one on the clear edge (R7)
        send(1'b1, 3, 3, 100, "R7 discarded");
        clr = 1'b1; sample_stb = 1'b1; row_match = 1'b1; vec_cat = 6'd3; train_cat = 6'd3;
        q.delete(); m_sum = 0; m_cnt = 0;
        @(negedge clk);
        clr = 1'b0;
        idle(4);
        check("R7 clear sum", int'(fit_sum), 0);
        check("R7 clear cnt", int'(sample_cnt), 0);

        // Saturation of score (R8) then count (R9)
        for (int i = 0; i < 5; i++) send(1'b1, 12, 12, 255, "R8 sum saturation");
        for (int i = 0; i < 3; i++) send(1'b0, 1, 2, 255, "R9 cnt saturation");
        idle(4);
        check("R8 final sum", int'(fit_sum), SUM_MAX);
        check("R9 final cnt", int'(sample_cnt), CNT_MAX);
        check("R6 queue drained", q.size(), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule